// File: doc/BRIEF.md
# Monochrome LCD Refresh Controller

This block keeps a 128 x 128 one-bit-per-pixel panel refreshed from a frame buffer held in system memory. It acts as a bus master: it requests the bus, waits for a grant, and reads two consecutive 32-bit frame-buffer words per grant into a three-word FIFO. A shift register takes one word at a time from the FIFO and presents it to the column driver as a stream of 4-bit nibbles. The raster size and all driver timing are fixed by parameters at build time and cannot be changed while running.

Next to the pixel stream the block generates every strobe the panel drivers need. These are a column shift clock per nibble, a line latch pulse and a row shift clock once per line, a row scan start level during the first line of a frame, and a frame signal that toggles once per frame. The memory address of each word is the concatenation of a base register and a 9-bit word index. The word index wraps after the last of the 512 frame words. The base register is taken from the `baseAddr` input whenever a burst begins at word 0. If the FIFO is ever empty when the shifter needs a word, the shifter sends blank pixels for that word and a sticky underrun flag is raised.

Top module: `mono_lcd_refresh`

## Requirements
- R1: While `rstN` is low, `busReq`, `rdStrobe`, `shiftClk`, `latchPulse`, `rowClk`, `rowStart`, `frameSig`, `underrun` and `pixData` are all 0.
- R2: `busReq` rises before any read and `rdStrobe` first rises only in the cycle after `busGnt` was seen high. Each grant carries exactly two words, one accepted per cycle in which `ack` is high with `rdStrobe`. `busReq` falls after the second word. With no grant, `rdStrobe` stays low.
- R3: `addrOut` is `{base, wordIndex}`, with the word index in the low 9 bits. The word index advances by one per accepted word and wraps from 511 to 0.
- R4: The base part of `addrOut` is the value `baseAddr` held in the cycle the grant for a burst starting at word 0 arrived. A change of `baseAddr` in mid-frame takes effect only at the next frame.
- R5: Frame words are shown in word-index order, 8 nibbles per word, starting with bits 31:28. Within a nibble, `pixData[3]` is the leftmost pixel.
- R6: Each nibble is held for SHIFT_DIV clocks (default 2). `shiftClk` is high for exactly one clock in each nibble period, and `pixData` does not change while it is high.
- R7: After every 32 nibbles (one 128-pixel line), `latchPulse` and `rowClk` are high together for one clock, in the clock that follows the line's last nibble period, while `shiftClk` is low.
- R8: `rowStart` is high for every nibble of line 0 of each frame and low for the other 127 lines.
- R9: `frameSig` changes only together with a `latchPulse`, and only once every 128 lines.
- R10: A burst is requested only while the FIFO has room for both of its words. With the grant answered promptly, the FIFO never underruns and `underrun` stays 0.
- R11: When a word is needed and the FIFO is empty, `underrun` is set and stays set until reset, and the 8 nibbles of that word are 0.
- R12: Pixel shifting starts only after the first burst of two words has been stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| baseAddr | input | 21 | Frame-buffer base (address bits above the word index) |
| busReq | output | 1 | Bus request for a two-word burst |
| busGnt | input | 1 | Bus grant |
| rdStrobe | output | 1 | Read in progress; the address is valid |
| addrOut | output | 30 | Word address (byte address bits 31:2) |
| rdData | input | 32 | Read data from memory |
| ack | input | 1 | Memory has placed the word on `rdData` |
| pixData | output | 4 | Pixel nibble to the column driver |
| shiftClk | output | 1 | Column data shift clock |
| latchPulse | output | 1 | Line latch pulse |
| rowClk | output | 1 | Row driver shift clock |
| rowStart | output | 1 | Row scan start (first line of the frame) |
| frameSig | output | 1 | Frame signal, toggles each frame |
| underrun | output | 1 | Sticky FIFO underrun flag |

## Verification
A stuck or skipped word index shows on `addrOut` at the very next accepted word. It also shows as wrong pixel nibbles roughly three words later, once that word reaches the shifter. A line or frame counter that is off by one moves `latchPulse`, `rowStart` or `frameSig` by a whole nibble period or line. This is caught at the first line boundary, or within the first frame for the frame signal. Wrong FIFO occupancy shows either as an underrun within one word time of the fault or as a lost word, which shifts every following nibble out of order. The bench compares every nibble against memory contents computed from the expected addresses, so a lost word is reported within eight nibbles.

// File: rtl/lcd_refresh_pkg.sv
package lcdPkg;

  // Strobes from the control module to the datapath
  typedef struct packed {
    logic push;     // store rdData into the FIFO, advance word index
    logic load;     // take the next word into the shifter
    logic shift;    // present the next nibble of the current word
    logic capBase;  // capture baseAddr into the base register
  } dpStrobe_t;

  typedef enum logic [1:0] {
    BUS_IDLE,
    BUS_REQ,
    BUS_XFER
  } busState_t;

endpackage

// File: rtl/lcd_refresh_ctl.sv
module lcd_refresh_ctl
  import lcdPkg::*;
#(
  parameter int SHIFT_DIV    = 2,
  parameter int BURST        = 2,
  parameter int FIFO_DEPTH   = 3,
  parameter int NIB_PER_WORD = 8,
  parameter int NIB_PER_LINE = 32,
  parameter int ROWS         = 128,
  parameter int CNT_W        = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             busGnt,
  input  logic             ack,
  input  logic [CNT_W-1:0] fifoCount,
  input  logic             wordIsZero,
  output dpStrobe_t        strb,
  output logic             busReq,
  output logic             rdStrobe,
  output logic             shiftClk,
  output logic             latchPulse,
  output logic             rowClk,
  output logic             rowStart,
  output logic             frameSig
);

  localparam int DIV_W  = $clog2(SHIFT_DIV + 1);
  localparam int HALF   = SHIFT_DIV / 2;
  localparam int NIBX_W = $clog2(NIB_PER_LINE);
  localparam int SUB_W  = $clog2(NIB_PER_WORD);
  localparam int LINE_W = $clog2(ROWS);
  localparam int BEAT_W = $clog2(BURST + 1);

  // ---------------- bus master sequencer ----------------
  busState_t         busSt;
  logic [BEAT_W-1:0] beatCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busSt   <= BUS_IDLE;
      beatCnt <= '0;
    end else begin
      case (busSt)
        BUS_IDLE: if (fifoCount <= CNT_W'(FIFO_DEPTH - BURST)) busSt <= BUS_REQ;
        BUS_REQ:  if (busGnt) busSt <= BUS_XFER;
        BUS_XFER: if (ack) begin
          if (beatCnt == BEAT_W'(BURST - 1)) begin
            busSt   <= BUS_IDLE;
            beatCnt <= '0;
          end else begin
            beatCnt <= beatCnt + 1'b1;
          end
        end
        default:  busSt <= BUS_IDLE;
      endcase
    end
  end

  assign busReq   = (busSt != BUS_IDLE);
  assign rdStrobe = (busSt == BUS_XFER);

  // ---------------- raster timing ----------------
  logic              running;
  logic [DIV_W-1:0]  divCnt;
  logic [NIBX_W-1:0] nibIdx;
  logic [LINE_W-1:0] lineIdx;
  logic              latchReg;
  logic              frameReg;

  logic startNow, periodEnd, lineEnd, wordEnd;

  assign startNow  = !running && (fifoCount >= CNT_W'(BURST));
  assign periodEnd = running && (divCnt == DIV_W'(SHIFT_DIV - 1));
  assign lineEnd   = (nibIdx == NIBX_W'(NIB_PER_LINE - 1));
  assign wordEnd   = &nibIdx[SUB_W-1:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      running  <= 1'b0;
      divCnt   <= '0;
      nibIdx   <= '0;
      lineIdx  <= '0;
      latchReg <= 1'b0;
      frameReg <= 1'b0;
    end else begin
      latchReg <= 1'b0;
      if (startNow) begin
        running <= 1'b1;
        divCnt  <= '0;
        nibIdx  <= '0;
        lineIdx <= '0;
      end else if (periodEnd) begin
        divCnt <= '0;
        if (lineEnd) begin
          nibIdx   <= '0;
          latchReg <= 1'b1;
          if (lineIdx == LINE_W'(ROWS - 1)) begin
            lineIdx  <= '0;
            frameReg <= ~frameReg;
          end else begin
            lineIdx <= lineIdx + 1'b1;
          end
        end else begin
          nibIdx <= nibIdx + 1'b1;
        end
      end else if (running) begin
        divCnt <= divCnt + 1'b1;
      end
    end
  end

  assign shiftClk   = running && (divCnt == DIV_W'(HALF));
  assign latchPulse = latchReg;
  assign rowClk     = latchReg;
  assign rowStart   = running && (lineIdx == '0);
  assign frameSig   = frameReg;

  always_comb begin
    strb         = '0;
    strb.push    = rdStrobe && ack;
    strb.capBase = (busSt == BUS_REQ) && busGnt && wordIsZero;
    strb.load    = startNow || (periodEnd && wordEnd);
    strb.shift   = periodEnd && !wordEnd;
  end

  // ---------------- assertions ----------------
  p_strobe_after_grant_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rdStrobe) |-> $past(busGnt));

  p_latch_one_cycle_r7: assert property (@(posedge clk) disable iff (!rstN)
    latchPulse |=> !latchPulse);

  p_latch_not_shift_r7: assert property (@(posedge clk) disable iff (!rstN)
    latchPulse |-> !shiftClk);

  p_frame_with_latch_r9: assert property (@(posedge clk) disable iff (!rstN)
    (frameSig != $past(frameSig)) |-> latchPulse);

  p_start_after_burst_r12: assert property (@(posedge clk) disable iff (!rstN)
    $rose(running) |-> $past(fifoCount >= CNT_W'(BURST)));

endmodule

// File: rtl/lcd_refresh_dp.sv
module lcd_refresh_dp
  import lcdPkg::*;
#(
  parameter int WORD_W      = 32,
  parameter int NIB_W       = 4,
  parameter int FIFO_DEPTH  = 3,
  parameter int FRAME_WORDS = 512,
  parameter int IDX_W       = 9,
  parameter int BASE_W      = 21,
  parameter int CNT_W       = 2
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  dpStrobe_t               strb,
  input  logic [BASE_W-1:0]       baseAddr,
  input  logic [WORD_W-1:0]       rdData,
  output logic [BASE_W+IDX_W-1:0] addrOut,
  output logic [CNT_W-1:0]        fifoCount,
  output logic                    wordIsZero,
  output logic [NIB_W-1:0]        pixData,
  output logic                    underrun
);

  localparam int PTR_W = (FIFO_DEPTH > 1) ? $clog2(FIFO_DEPTH) : 1;

  logic [WORD_W-1:0] fifoMem [FIFO_DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;
  logic [CNT_W-1:0]  count;
  logic [IDX_W-1:0]  wordCnt;
  logic [BASE_W-1:0] baseReg;
  logic [WORD_W-1:0] shReg;
  logic              doPop;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(FIFO_DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign doPop = strb.load && (count != '0);

  always_ff @(posedge clk) begin
    if (strb.push) fifoMem[wrPtr] <= rdData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr    <= '0;
      rdPtr    <= '0;
      count    <= '0;
      wordCnt  <= '0;
      baseReg  <= '0;
      shReg    <= '0;
      pixData  <= '0;
      underrun <= 1'b0;
    end else begin
      if (strb.push) begin
        wrPtr   <= bump(wrPtr);
        wordCnt <= (wordCnt == IDX_W'(FRAME_WORDS - 1)) ? '0 : wordCnt + 1'b1;
      end
      if (doPop) rdPtr <= bump(rdPtr);
      case ({strb.push, doPop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
      if (strb.capBase) baseReg <= baseAddr;

      if (strb.load) begin
        if (doPop) begin
          pixData <= fifoMem[rdPtr][WORD_W-1 -: NIB_W];
          shReg   <= fifoMem[rdPtr] << NIB_W;
        end else begin
          pixData  <= '0;
          shReg    <= '0;
          underrun <= 1'b1;
        end
      end else if (strb.shift) begin
        pixData <= shReg[WORD_W-1 -: NIB_W];
        shReg   <= shReg << NIB_W;
      end
    end
  end

  assign addrOut    = {baseReg, wordCnt};
  assign fifoCount  = count;
  assign wordIsZero = (wordCnt == '0);

  // ---------------- assertions ----------------
  p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rstN)
    strb.push |-> (count < CNT_W'(FIFO_DEPTH)));

  p_underrun_sticky_r11: assert property (@(posedge clk) disable iff (!rstN)
    underrun |=> underrun);

  p_blank_on_starve_r11: assert property (@(posedge clk) disable iff (!rstN)
    (strb.load && count == '0) |=> (pixData == '0));

  p_index_wraps_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strb.push && wordCnt == IDX_W'(FRAME_WORDS - 1)) |=> (wordCnt == '0));

endmodule

// File: rtl/mono_lcd_refresh.sv
module mono_lcd_refresh
  import lcdPkg::*;
#(
  parameter int COLS       = 128,
  parameter int ROWS       = 128,
  parameter int WORD_W     = 32,
  parameter int NIB_W      = 4,
  parameter int SHIFT_DIV  = 2,
  parameter int BURST      = 2,
  parameter int FIFO_DEPTH = 3,
  parameter int ADDR_W     = 30,
  localparam int FRAME_WORDS = COLS * ROWS / WORD_W,
  localparam int IDX_W       = $clog2(FRAME_WORDS),
  localparam int BASE_W      = ADDR_W - IDX_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [BASE_W-1:0] baseAddr,
  output logic              busReq,
  input  logic              busGnt,
  output logic              rdStrobe,
  output logic [ADDR_W-1:0] addrOut,
  input  logic [WORD_W-1:0] rdData,
  input  logic              ack,
  output logic [NIB_W-1:0]  pixData,
  output logic              shiftClk,
  output logic              latchPulse,
  output logic              rowClk,
  output logic              rowStart,
  output logic              frameSig,
  output logic              underrun
);

  localparam int CNT_W        = $clog2(FIFO_DEPTH + 1);
  localparam int NIB_PER_WORD = WORD_W / NIB_W;
  localparam int NIB_PER_LINE = COLS / NIB_W;

  dpStrobe_t        strb;
  logic [CNT_W-1:0] fifoCount;
  logic             wordIsZero;

  lcd_refresh_ctl #(
    .SHIFT_DIV   (SHIFT_DIV),
    .BURST       (BURST),
    .FIFO_DEPTH  (FIFO_DEPTH),
    .NIB_PER_WORD(NIB_PER_WORD),
    .NIB_PER_LINE(NIB_PER_LINE),
    .ROWS        (ROWS),
    .CNT_W       (CNT_W)
  ) uCtl (
    .clk       (clk),
    .rstN      (rstN),
    .busGnt    (busGnt),
    .ack       (ack),
    .fifoCount (fifoCount),
    .wordIsZero(wordIsZero),
    .strb      (strb),
    .busReq    (busReq),
    .rdStrobe  (rdStrobe),
    .shiftClk  (shiftClk),
    .latchPulse(latchPulse),
    .rowClk    (rowClk),
    .rowStart  (rowStart),
    .frameSig  (frameSig)
  );

  lcd_refresh_dp #(
    .WORD_W     (WORD_W),
    .NIB_W      (NIB_W),
    .FIFO_DEPTH (FIFO_DEPTH),
    .FRAME_WORDS(FRAME_WORDS),
    .IDX_W      (IDX_W),
    .BASE_W     (BASE_W),
    .CNT_W      (CNT_W)
  ) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .baseAddr  (baseAddr),
    .rdData    (rdData),
    .addrOut   (addrOut),
    .fifoCount (fifoCount),
    .wordIsZero(wordIsZero),
    .pixData   (pixData),
    .underrun  (underrun)
  );

endmodule

// File: tb/sim_mono_lcd_refresh.sv
`timescale 1ns/1ps
module sim_mono_lcd_refresh;

  localparam int SHIFT_DIV = 2;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [20:0] baseAddr = 21'h12345;
  logic        busReq, busGnt = 1'b0, rdStrobe, ack = 1'b0;
  logic [29:0] addrOut;
  logic [31:0] rdData = '0;
  logic [3:0]  pixData;
  logic        shiftClk, latchPulse, rowClk, rowStart, frameSig, underrun;

  always #2.5 clk = ~clk;

  mono_lcd_refresh u0 (
    .clk(clk), .rstN(rstN), .baseAddr(baseAddr),
    .busReq(busReq), .busGnt(busGnt), .rdStrobe(rdStrobe), .addrOut(addrOut),
    .rdData(rdData), .ack(ack), .pixData(pixData), .shiftClk(shiftClk),
    .latchPulse(latchPulse), .rowClk(rowClk), .rowStart(rowStart),
    .frameSig(frameSig), .underrun(underrun)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  bit gntEn = 1'b1;
  bit scoreEn = 1'b1;

  function automatic logic [31:0] memWord(input logic [29:0] a);
    return {a[15:0] ^ 16'h5A3C, a[15:0] + 16'h1357} | 32'h1;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // behavioural bus grant and memory slave
  always @(posedge clk) begin
    busGnt <= gntEn && busReq;
    ack    <= rdStrobe && !ack;
    rdData <= memWord(addrOut);
  end

  // ---------------- scoreboard ----------------
  logic [3:0]  expQ[$];
  logic [20:0] curBase = '0;
  int          wordK = 0;
  int          burstAcks = 0;
  int          ackTotal = 0;
  int          wraps = 0;
  int          baseSeen = 0;
  bit          prevReq = 1'b0;
  bit          prevShift = 1'b0;
  logic [3:0]  prevPix = '0;
  int          cycle = 0;
  int          lastShiftCycle = -1;
  int          nibInLine = 0;
  int          linesDone = 0;
  bit          lastFrame = 1'b0;

  // driver: expected words pushed as each read is accepted
  task automatic pushWord(input logic [29:0] a);
    logic [31:0] w;
    w = memWord(a);
    for (int n = 7; n >= 0; n--) expQ.push_back(w[n*4 +: 4]);
  endtask

  always @(negedge clk) begin
    cycle++;
    if (rstN) begin
      if (ack && rdStrobe) begin
        logic [29:0] expA;
        if (wordK == 0) begin
          curBase = baseAddr;
          check(addrOut[29:9] == baseAddr, "R4", "base at word 0", addrOut[29:9], baseAddr);
          if (ackTotal > 0) begin
            wraps++;
            check(1'b1, "R3", "index wrapped 511->0", 0, 0);
          end
          if (baseAddr == 21'h0ABCD) baseSeen++;
        end
        expA = {curBase, 9'(wordK)};
        check(addrOut == expA, "R3", "read address", addrOut, expA);
        pushWord(expA);
        wordK = (wordK + 1) % 512;
        burstAcks++;
        ackTotal++;
      end
      if (prevReq && !busReq) begin
        check(burstAcks == 2, "R2", "words per grant", burstAcks, 2);
        burstAcks = 0;
      end
      prevReq = busReq;
      check(rowClk == latchPulse, "R7", "rowClk with latchPulse", rowClk, latchPulse);

      if (shiftClk) begin
        if (lastShiftCycle < 0)
          check(ackTotal >= 2, "R12", "words stored before shifting", ackTotal, 2);
        else if (scoreEn)
          check(cycle - lastShiftCycle == SHIFT_DIV, "R6", "nibble period",
                cycle - lastShiftCycle, SHIFT_DIV);
        if (scoreEn) begin
          check(pixData == prevPix, "R6", "pixData stable at shiftClk", pixData, prevPix);
          if (expQ.size() == 0) begin
            check(1'b0, "R5", "nibble with empty expectation queue", pixData, 0);
          end else begin
            logic [3:0] e;
            e = expQ.pop_front();
            check(pixData == e, "R5", "pixel nibble", pixData, e);
          end
          check(rowStart == (linesDone % 128 == 0), "R8", "rowStart level",
                rowStart, (linesDone % 128 == 0));
          check(underrun == 1'b0, "R10", "no underrun while granted", underrun, 0);
        end
        lastShiftCycle = cycle;
        nibInLine++;
      end

      if (latchPulse && scoreEn) begin
        linesDone++;
        check(nibInLine == 32, "R7", "nibbles per line", nibInLine, 32);
        check(shiftClk == 1'b0, "R7", "shiftClk low at latch", shiftClk, 0);
        check((frameSig != lastFrame) == (linesDone % 128 == 0), "R9", "frame toggle",
              frameSig, lastFrame ^ (linesDone % 128 == 0));
        lastFrame = frameSig;
        nibInLine = 0;
      end
      if (latchPulse && !scoreEn) nibInLine = 0;
    end
    prevPix = pixData;
  end

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL R12 watchdog expired: actual=%0d expected=<150000 cycles", 150000);
      summary();
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (6) @(negedge clk);
    check({busReq, rdStrobe, shiftClk, latchPulse, rowClk, rowStart, frameSig, underrun} == 8'h0,
          "R1", "control outputs in reset",
          {busReq, rdStrobe, shiftClk, latchPulse, rowClk, rowStart, frameSig, underrun}, 0);
    check(pixData == 4'h0, "R1", "pixData in reset", pixData, 0);
    @(negedge clk);
    rstN = 1'b1;

    // main refresh with base change in frame 0
    while (linesDone < 40) @(negedge clk);
    baseAddr = 21'h0ABCD;
    while (linesDone < 2 * 128 + 4) @(negedge clk);
    check(wraps >= 2, "R3", "wrap count", wraps, 2);
    check(baseSeen >= 1, "R4", "new base used at next frame", baseSeen, 1);
    check(underrun == 1'b0, "R10", "no underrun after two frames", underrun, 0);

    // starvation
    scoreEn = 1'b0;
    gntEn = 1'b0;
    for (int i = 0; i < 400 && !underrun; i++) @(negedge clk);
    check(underrun == 1'b1, "R11", "underrun raised when starved", underrun, 1);
    check(busReq == 1'b1 && rdStrobe == 1'b0, "R2", "no read without grant",
          {busReq, rdStrobe}, 2'b10);
    for (int n = 0; n < 16; n++) begin
      while (!shiftClk) @(negedge clk);
      check(pixData == 4'h0, "R11", "blank nibble while starved", pixData, 0);
      @(negedge clk);
    end
    gntEn = 1'b1;
    repeat (200) @(negedge clk);
    check(underrun == 1'b1, "R11", "underrun stays set", underrun, 1);

    finished = 1'b1;
    summary();
    $finish;
  end

endmodule